// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block keeps a bank of receive statistics for each of a set of input ports. A frame receiver hands it one completion record per packet. The record carries the port number, the byte length including the 4-byte frame check sequence, and these flags: bad FCS or alignment, marked for drop, L2 multicast, L2 broadcast, parsed from L2, and interface error. The record is classified, and every counter of that port that the packet qualifies for is advanced by one packet or by its octet count in the same clock edge. Each counter saturates at its all-ones value.

Software-facing logic reads any counter through a registered read port: it gives a port and a counter code and gets the value one cycle later. A global clear-on-read control makes every read also zero the counter it returns. The runt/oversize thresholds come in as plain control inputs (64 and 1518 in normal use). The record interface is valid/ready. Ready is low during reset and held high after it, so the sender never stalls once reset is released. A record is consumed in every cycle in which valid and ready are both high, and its fields only need to be stable in those cycles.

Top module: `rx_port_stats`

## Requirements
- R1: `in_ready` is low while `rst_n` is low and high from the first clock after reset. A record is taken on every edge with `in_valid` and `in_ready` high, and its effect is visible to a read issued in the next cycle.
- R2: After reset every counter of every port reads zero and `rd_valid` is low.
- R3: A read strobe `rd_en` with `rd_port`/`rd_sel` gives `rd_valid` high with `rd_data` one cycle later, holding the counter value from before that edge. The codes for `rd_sel` are: 0 dropped octets, 1 dropped packets, 2 processed octets, 3 processed packets, 4 multicast, 5 broadcast, 6 length 64, 7 65–127, 8 128–255, 9 256–511, 10 512–1023, 11 1024–1518, 12 1519 up to the maximum, 13 FCS/alignment errors, 14 runt, 15 fragment, 16 oversize, 17 jabber, 18 clean inbound packets, 19 inbound octets, 20 inbound errored packets. Codes 21 and above read zero.
- R4: A packet with the drop flag adds 1 to dropped packets and its length minus 4 (floored at 0) to dropped octets. Any other packet adds to processed packets and processed octets in the same way.
- R5: Every packet adds its full length, CRC bytes included, to inbound octets. It adds 1 to inbound errored packets when the interface-error flag is set, and to clean inbound packets otherwise.
- R6: Broadcast and multicast counts only move for packets with the parsed-from-L2 flag set. A packet flagged both ways counts as broadcast only.
- R7: Histogram bins have fixed edges: exactly 64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, and 1519 up to the programmed maximum. A packet longer than the maximum or shorter than 64 lands in no bin. The bins do not depend on the minimum.
- R8: A packet shorter than `min_len` counts as runt with a good FCS and as fragment with a bad one. A packet longer than `max_len` counts as oversize with a good FCS and as jabber with a bad one.
- R9: Every packet with the FCS/alignment flag adds 1 to the FCS error count, whatever its length.
- R10: With `clr_on_rd` high, a read returns the old value and zeros that one counter. With it low, reads leave counters unchanged.
- R11: When a clearing read and an update hit the same counter in the same cycle, the read returns the value before the update, and the counter then holds exactly that update's increment.
- R12: Inbound octets is 64 bits wide, inbound errored packets is 16 bits, and every other counter is 32 bits. All saturate at all-ones, and narrow values are zero-extended on `rd_data`.
- R13: A record updates only the counters of its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Completion record valid |
| in_ready | output | 1 | Block can take a record |
| in_port | input | PORT_W | Port the packet arrived on |
| in_len | input | LEN_W | Packet length in bytes, CRC included |
| in_fcs_err | input | 1 | Bad FCS or alignment |
| in_drop | input | 1 | Packet marked for drop |
| in_mcast | input | 1 | L2 multicast destination |
| in_bcast | input | 1 | L2 broadcast destination |
| in_skip_l2 | input | 1 | Packet was parsed from its L2 header |
| in_if_err | input | 1 | Interface reported an error |
| min_len | input | LEN_W | Runt threshold |
| max_len | input | LEN_W | Oversize threshold and top of the last bin |
| clr_on_rd | input | 1 | Global clear-on-read control |
| rd_en | input | 1 | Read strobe |
| rd_port | input | PORT_W | Port to read |
| rd_sel | input | 5 | Counter code to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | WIDE_W | Counter value, zero-extended |

## Verification
The hard case is a clearing read and a record update that land on the same counter in the same cycle. The bench first sends one packet to a port. It then asserts a clearing read of that port's processed-packet counter on the same edge as a second packet for that port. It judges the outcome at the ports: the read data must show the count before the second packet, and a later non-clearing read must show exactly one. A lost update would read zero and a summed one would read two. The same collision also lets the other counters of the port take the second packet, which the full sweep of that port confirms.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int SEL_W = 5;

  typedef enum logic [SEL_W-1:0] {
    CTR_DROP_OCTS = 5'd0,
    CTR_DROP_PKTS = 5'd1,
    CTR_OCTS      = 5'd2,
    CTR_PKTS      = 5'd3,
    CTR_MCAST     = 5'd4,
    CTR_BCAST     = 5'd5,
    CTR_H64       = 5'd6,
    CTR_H65       = 5'd7,
    CTR_H128      = 5'd8,
    CTR_H256      = 5'd9,
    CTR_H512      = 5'd10,
    CTR_H1024     = 5'd11,
    CTR_H1519     = 5'd12,
    CTR_FCS       = 5'd13,
    CTR_RUNT      = 5'd14,
    CTR_FRAG      = 5'd15,
    CTR_OVERSZ    = 5'd16,
    CTR_JABBER    = 5'd17,
    CTR_INB_PKTS  = 5'd18,
    CTR_INB_OCTS  = 5'd19,
    CTR_INB_ERRS  = 5'd20
  } ctr_e;

  localparam int NUM_CTR = 21;
  localparam int CRC_BYTES = 4;

  // fixed histogram edges (upper bound of each bin)
  localparam int BIN_64   = 64;
  localparam int BIN_127  = 127;
  localparam int BIN_255  = 255;
  localparam int BIN_511  = 511;
  localparam int BIN_1023 = 1023;
  localparam int BIN_1518 = 1518;

endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0]                len_i,
  input  logic                            fcs_i,
  input  logic                            drop_i,
  input  logic                            mcast_i,
  input  logic                            bcast_i,
  input  logic                            skip_l2_i,
  input  logic                            if_err_i,
  input  logic [LEN_W-1:0]                min_len_i,
  input  logic [LEN_W-1:0]                max_len_i,
  output logic [NUM_CTR-1:0][LEN_W-1:0]   inc_o
);

  logic [LEN_W-1:0] one;
  logic [LEN_W-1:0] pay;
  logic             binable;
  logic             short_pkt;
  logic             long_pkt;

  assign one       = LEN_W'(1);
  assign pay       = (len_i >= LEN_W'(CRC_BYTES)) ? (len_i - LEN_W'(CRC_BYTES)) : '0;
  assign binable   = (len_i >= LEN_W'(BIN_64)) && (len_i <= max_len_i);
  assign short_pkt = len_i < min_len_i;
  assign long_pkt  = len_i > max_len_i;

  always_comb begin
    inc_o = '0;
    // drop / processed split
    if (drop_i) begin
      inc_o[int'(CTR_DROP_OCTS)] = pay;
      inc_o[int'(CTR_DROP_PKTS)] = one;
    end else begin
      inc_o[int'(CTR_OCTS)] = pay;
      inc_o[int'(CTR_PKTS)] = one;
    end
    // L2 address class, broadcast wins
    if (skip_l2_i && bcast_i)
      inc_o[int'(CTR_BCAST)] = one;
    else if (skip_l2_i && mcast_i)
      inc_o[int'(CTR_MCAST)] = one;
    // size histogram
    if (binable) begin
      if (len_i == LEN_W'(BIN_64))
        inc_o[int'(CTR_H64)] = one;
      else if (len_i <= LEN_W'(BIN_127))
        inc_o[int'(CTR_H65)] = one;
      else if (len_i <= LEN_W'(BIN_255))
        inc_o[int'(CTR_H128)] = one;
      else if (len_i <= LEN_W'(BIN_511))
        inc_o[int'(CTR_H256)] = one;
      else if (len_i <= LEN_W'(BIN_1023))
        inc_o[int'(CTR_H512)] = one;
      else if (len_i <= LEN_W'(BIN_1518))
        inc_o[int'(CTR_H1024)] = one;
      else
        inc_o[int'(CTR_H1519)] = one;
    end
    if (fcs_i)
      inc_o[int'(CTR_FCS)] = one;
    // length violations split by FCS status
    if (short_pkt) begin
      if (fcs_i) inc_o[int'(CTR_FRAG)] = one;
      else       inc_o[int'(CTR_RUNT)] = one;
    end
    if (long_pkt) begin
      if (fcs_i) inc_o[int'(CTR_JABBER)] = one;
      else       inc_o[int'(CTR_OVERSZ)] = one;
    end
    // inbound totals
    inc_o[int'(CTR_INB_OCTS)] = len_i;
    if (if_err_i)
      inc_o[int'(CTR_INB_ERRS)] = one;
    else
      inc_o[int'(CTR_INB_PKTS)] = one;
  end

endmodule

// File: rtl/rxs_sat_counter.sv
module rxs_sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 16,
  parameter int OUT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  input  logic             clr_i,
  output logic [OUT_W-1:0] val_o
);

  logic [W-1:0] cnt_q;
  logic [W:0]   sum;
  logic [W-1:0] nxt;

  assign sum = {1'b0, cnt_q} + (W+1)'(inc_i);

  always_comb begin
    if (clr_i)
      nxt = W'(inc_i);            // update survives the clear
    else if (sum[W])
      nxt = '1;                   // saturate
    else
      nxt = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;
  end

  assign val_o = OUT_W'(cnt_q);

endmodule

// File: rtl/rxs_port_bank.sv
module rxs_port_bank
  import rxs_pkg::*;
#(
  parameter int PORT_ID = 0,
  parameter int PORT_W  = 2,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 32,
  parameter int WIDE_W  = 64,
  parameter int ERR_W   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           upd_i,
  input  logic [PORT_W-1:0]              upd_port_i,
  input  logic [NUM_CTR-1:0][LEN_W-1:0]  inc_i,
  input  logic                           clr_rd_i,
  input  logic [PORT_W-1:0]              rd_port_i,
  input  logic [SEL_W-1:0]               rd_sel_i,
  output logic [NUM_CTR-1:0][WIDE_W-1:0] vals_o
);

  logic hit;
  logic rd_mine;

  assign hit     = upd_i && (upd_port_i == PORT_W'(PORT_ID));
  assign rd_mine = clr_rd_i && (rd_port_i == PORT_W'(PORT_ID));

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    localparam int CW = (c == int'(CTR_INB_OCTS)) ? WIDE_W :
                        (c == int'(CTR_INB_ERRS)) ? ERR_W  : CNT_W;
    logic [LEN_W-1:0] inc;
    logic             clr;
    assign inc = hit ? inc_i[c] : '0;
    assign clr = rd_mine && (rd_sel_i == SEL_W'(c));
    rxs_sat_counter #(
      .W    (CW),
      .INC_W(LEN_W),
      .OUT_W(WIDE_W)
    ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc_i(inc),
      .clr_i(clr),
      .val_o(vals_o[c])
    );
  end

endmodule

// File: rtl/rx_port_stats.sv
module rx_port_stats
  import rxs_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 64,
  parameter int ERR_W  = 16,
  parameter int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PORT_W-1:0] in_port,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_fcs_err,
  input  logic              in_drop,
  input  logic              in_mcast,
  input  logic              in_bcast,
  input  logic              in_skip_l2,
  input  logic              in_if_err,
  input  logic [LEN_W-1:0]  min_len,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              clr_on_rd,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              rd_valid,
  output logic [WIDE_W-1:0] rd_data
);

  logic                                        rdy_q;
  logic                                        accept;
  logic [NUM_CTR-1:0][LEN_W-1:0]               inc;
  logic [NPORTS-1:0][NUM_CTR-1:0][WIDE_W-1:0]  vals;
  logic [WIDE_W-1:0]                           rd_mux;
  logic                                        rd_ok;
  logic                                        rd_valid_q;
  logic [WIDE_W-1:0]                           rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign accept   = in_valid && rdy_q;

  rxs_classify #(.LEN_W(LEN_W)) u_class (
    .len_i    (in_len),
    .fcs_i    (in_fcs_err),
    .drop_i   (in_drop),
    .mcast_i  (in_mcast),
    .bcast_i  (in_bcast),
    .skip_l2_i(in_skip_l2),
    .if_err_i (in_if_err),
    .min_len_i(min_len),
    .max_len_i(max_len),
    .inc_o    (inc)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rxs_port_bank #(
      .PORT_ID(p),
      .PORT_W (PORT_W),
      .LEN_W  (LEN_W),
      .CNT_W  (CNT_W),
      .WIDE_W (WIDE_W),
      .ERR_W  (ERR_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_i     (accept),
      .upd_port_i(in_port),
      .inc_i     (inc),
      .clr_rd_i  (rd_en && clr_on_rd),
      .rd_port_i (rd_port),
      .rd_sel_i  (rd_sel),
      .vals_o    (vals[p])
    );
  end

  assign rd_ok = (rd_sel < SEL_W'(NUM_CTR)) &&
                 ({1'b0, rd_port} < (PORT_W+1)'(NPORTS));

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORTS; p++) begin
      for (int c = 0; c < NUM_CTR; c++) begin
        if (rd_ok && (rd_port == PORT_W'(p)) && (rd_sel == SEL_W'(c)))
          rd_mux = vals[p][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/rx_port_stats_chk.sv
module rx_port_stats_chk
  import rxs_pkg::*;
#(
  parameter int PORT_W = 2,
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              clr_on_rd,
  input logic              rd_en,
  input logic [PORT_W-1:0] rd_port,
  input logic [SEL_W-1:0]  rd_sel,
  input logic              rd_valid,
  input logic [WIDE_W-1:0] rd_data
);

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R3
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R12
  narrow_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_sel) != SEL_W'(CTR_INB_OCTS))
      |-> rd_data[WIDE_W-1:CNT_W] == '0);

  // R10
  no_clear_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) &&
     $past(rd_port) == $past(rd_port, 2) &&
     $past(rd_sel) == $past(rd_sel, 2) &&
     !$past(clr_on_rd, 2))
      |-> rd_data >= $past(rd_data));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) &&
     $past(rd_port) == $past(rd_port, 2) &&
     $past(rd_sel) == $past(rd_sel, 2) &&
     $past(clr_on_rd, 2) && !$past(in_valid, 2))
      |-> rd_data == '0);

endmodule

bind rx_port_stats rx_port_stats_chk #(
  .PORT_W(PORT_W),
  .CNT_W (CNT_W),
  .WIDE_W(WIDE_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .clr_on_rd(clr_on_rd),
  .rd_en    (rd_en),
  .rd_port  (rd_port),
  .rd_sel   (rd_sel),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/rx_port_stats_tb_top.sv
module rx_port_stats_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int NC  = 21;
  localparam int LW  = 16;
  localparam int PW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_port = '0;
  logic [LW-1:0] in_len = '0;
  logic          in_fcs_err = 1'b0;
  logic          in_drop = 1'b0;
  logic          in_mcast = 1'b0;
  logic          in_bcast = 1'b0;
  logic          in_skip_l2 = 1'b0;
  logic          in_if_err = 1'b0;
  logic [LW-1:0] min_len = 16'd64;
  logic [LW-1:0] max_len = 16'd1518;
  logic          clr_on_rd = 1'b0;
  logic          rd_en = 1'b0;
  logic [PW-1:0] rd_port = '0;
  logic [4:0]    rd_sel = '0;
  logic          rd_valid;
  logic [63:0]   rd_data;

  int n_chk = 0;
  int n_fail = 0;
  longint unsigned exp_v [NP][NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_port_stats dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_port(in_port), .in_len(in_len), .in_fcs_err(in_fcs_err),
    .in_drop(in_drop), .in_mcast(in_mcast), .in_bcast(in_bcast),
    .in_skip_l2(in_skip_l2), .in_if_err(in_if_err),
    .min_len(min_len), .max_len(max_len), .clr_on_rd(clr_on_rd),
    .rd_en(rd_en), .rd_port(rd_port), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req,
                     input longint unsigned act, input longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic string req_of(input int s);
    if (s <= 3) return "R4";
    if (s <= 5) return "R6";
    if (s <= 12) return "R7";
    if (s == 13) return "R9";
    if (s <= 17) return "R8";
    return "R5";
  endfunction

  function automatic longint unsigned lim_of(input int s);
    if (s == 19) return 64'hFFFF_FFFF_FFFF_FFFF;
    if (s == 20) return 64'hFFFF;
    return 64'hFFFF_FFFF;
  endfunction

  task automatic madd(input int p, input int s, input longint unsigned inc);
    longint unsigned lim = lim_of(s);
    if (lim - exp_v[p][s] < inc) exp_v[p][s] = lim;
    else exp_v[p][s] = exp_v[p][s] + inc;
  endtask

  // bench model built from the requirements
  task automatic model(input int p, input int len, input bit fcs, input bit drop,
                       input bit mc, input bit bc, input bit skip, input bit ie);
    int pay = (len >= 4) ? len - 4 : 0;
    int mx = int'(max_len);
    int mn = int'(min_len);
    if (drop) begin madd(p, 0, longint'(pay)); madd(p, 1, 1); end
    else      begin madd(p, 2, longint'(pay)); madd(p, 3, 1); end
    if (skip && bc) madd(p, 5, 1);
    else if (skip && mc) madd(p, 4, 1);
    if (len >= 64 && len <= mx) begin
      if (len == 64)        madd(p, 6, 1);
      else if (len <= 127)  madd(p, 7, 1);
      else if (len <= 255)  madd(p, 8, 1);
      else if (len <= 511)  madd(p, 9, 1);
      else if (len <= 1023) madd(p, 10, 1);
      else if (len <= 1518) madd(p, 11, 1);
      else                  madd(p, 12, 1);
    end
    if (fcs) madd(p, 13, 1);
    if (len < mn) madd(p, fcs ? 15 : 14, 1);
    if (len > mx) madd(p, fcs ? 17 : 16, 1);
    madd(p, 19, longint'(len));
    madd(p, ie ? 20 : 18, 1);
  endtask

  task automatic drive_rec(input int p, input int len, input bit fcs, input bit drop,
                           input bit mc, input bit bc, input bit skip, input bit ie);
    in_valid = 1'b1; in_port = PW'(p); in_len = LW'(len);
    in_fcs_err = fcs; in_drop = drop; in_mcast = mc; in_bcast = bc;
    in_skip_l2 = skip; in_if_err = ie;
  endtask

  task automatic send(input int p, input int len, input bit fcs, input bit drop,
                      input bit mc, input bit bc, input bit skip, input bit ie);
    @(negedge clk);
    drive_rec(p, len, fcs, drop, mc, bc, skip, ie);
    model(p, len, fcs, drop, mc, bc, skip, ie);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic read_ctr(input int p, input int s, input bit clr,
                          output longint unsigned val);
    @(negedge clk);
    rd_en = 1'b1; rd_port = PW'(p); rd_sel = 5'(s); clr_on_rd = clr;
    @(posedge clk); #1;
    rd_en = 1'b0; clr_on_rd = 1'b0;
    @(negedge clk);
    val = rd_data;
    chk(rd_valid === 1'b1, "R3", longint'(rd_valid), 1);
    if (clr && s < NC) exp_v[p][s] = 0;
  endtask

  task automatic chk_all(input int p, input string tag);
    longint unsigned v;
    for (int s = 0; s < NC; s++) begin
      read_ctr(p, s, 1'b0, v);
      chk(v == exp_v[p][s], (tag == "") ? req_of(s) : tag, v, exp_v[p][s]);
    end
  endtask

  task automatic t_reset();
    chk(in_ready === 1'b0, "R1", longint'(in_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(in_ready === 1'b1, "R1", longint'(in_ready), 1);
    chk(rd_valid === 1'b0, "R2", longint'(rd_valid), 0);
    for (int p = 0; p < NP; p++) chk_all(p, "R2");
  endtask

  task automatic t_mix();
    send(0, 64, 0, 0, 1, 0, 1, 0);     // multicast, 64 bin
    send(0, 100, 0, 0, 1, 1, 1, 0);    // both flags: broadcast only
    send(0, 300, 0, 0, 1, 0, 0, 0);    // not parsed from L2
    send(0, 600, 0, 1, 0, 1, 0, 0);    // dropped
    send(0, 1200, 1, 0, 0, 0, 1, 0);   // FCS error in range
    send(0, 1518, 0, 0, 0, 0, 1, 0);
    send(0, 1519, 0, 0, 0, 0, 1, 0);   // oversize
    send(0, 1600, 1, 0, 0, 0, 1, 0);   // jabber
    send(0, 40, 0, 0, 0, 0, 1, 0);     // runt
    send(0, 40, 1, 1, 0, 0, 1, 0);     // fragment, dropped
    send(0, 2, 0, 0, 0, 0, 1, 1);      // shorter than CRC, interface error
    send(1, 200, 0, 0, 0, 1, 1, 1);    // other port
    chk_all(0, "");
    chk_all(1, "");
    chk_all(2, "R13");
  endtask

  task automatic t_limits();
    min_len = 16'd100; max_len = 16'd2000;
    send(1, 1800, 0, 0, 0, 0, 1, 0);   // 1519..max bin
    send(1, 80, 0, 0, 0, 0, 1, 0);     // runt and 65-127 bin
    send(1, 2100, 1, 0, 0, 0, 1, 0);   // jabber
    chk_all(1, "");
    max_len = 16'd1000;
    send(1, 1200, 0, 0, 0, 0, 1, 0);   // oversize, no bin
    chk_all(1, "R7");
    min_len = 16'd64; max_len = 16'd1518;
  endtask

  task automatic t_clear();
    longint unsigned v, e;
    e = exp_v[0][3];
    read_ctr(0, 3, 1'b1, v);
    chk(v == e, "R10", v, e);
    read_ctr(0, 3, 1'b0, v);
    chk(v == 0, "R10", v, 0);
    read_ctr(0, 2, 1'b0, v);
    chk(v == exp_v[0][2], "R10", v, exp_v[0][2]);
    read_ctr(0, 2, 1'b0, v);
    chk(v == exp_v[0][2], "R10", v, exp_v[0][2]);
  endtask

  task automatic t_collide();
    longint unsigned v, e;
    send(0, 70, 0, 0, 0, 0, 1, 0);
    e = exp_v[0][3];
    @(negedge clk);
    drive_rec(0, 90, 0, 0, 0, 0, 1, 0);
    rd_en = 1'b1; rd_port = 0; rd_sel = 5'd3; clr_on_rd = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; rd_en = 1'b0; clr_on_rd = 1'b0;
    @(negedge clk);
    v = rd_data;
    chk(v == e, "R11", v, e);
    exp_v[0][3] = 0;
    model(0, 90, 0, 0, 0, 0, 1, 0);
    read_ctr(0, 3, 1'b0, v);
    chk(v == 1, "R11", v, 1);
    chk_all(0, "");
  endtask

  task automatic t_bad_sel();
    longint unsigned v;
    read_ctr(0, 25, 1'b0, v);
    chk(v == 0, "R3", v, 0);
    read_ctr(0, 21, 1'b1, v);
    chk(v == 0, "R3", v, 0);
  endtask

  task automatic t_saturate();
    longint unsigned v;
    @(negedge clk);
    for (int i = 0; i < 65536; i++) begin
      drive_rec(3, 64, 0, 0, 0, 0, 0, 1);
      model(3, 64, 0, 0, 0, 0, 0, 1);
      if (i == 100) chk(in_ready === 1'b1, "R1", longint'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    read_ctr(3, 20, 1'b0, v);
    chk(v == 64'hFFFF, "R12", v, 64'hFFFF);
    read_ctr(3, 19, 1'b0, v);
    chk(v == 64'd4194304, "R12", v, 64'd4194304);
    chk_all(3, "");
  endtask

  initial begin
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NC; s++) exp_v[p][s] = 0;
    #(CLK_PERIOD * 2);
    t_reset();
    t_mix();
    t_limits();
    t_clear();
    t_collide();
    t_bad_sel();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 180000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule